// File: doc/BRIEF.md
# Power Mode Control Unit

This block sets the run, idle and power-down state of a small 8-bit microcontroller core. Software writes a byte-wide configuration register. One bit freezes only the CPU clock (idle) and another stops the oscillator and every clock (power-down). Two more bits are plain flags that software can keep across a sleep. The block drives a CPU clock enable, a peripheral clock enable and an oscillator enable. It also drives a core reset that is filtered from a raw reset pin.

An enabled interrupt ends idle. Power-down ends only on a low level on an enabled external interrupt line. After power-down ends, the oscillator runs again, but no clock is given back until an oscillator-ready input has stayed high for a parameterized number of cycles. The CPU clock stays off until the waking line goes inactive again. The reset pin clears both sleep bits at once, without waiting for a clock. The core reset asserts only when the pin has been held high for long enough.

Top module: `pwr_mode_ctl`

## Requirements
- R1: The register reads back as {4'b0000, GF1 at bit 3, GF0 at bit 2, PD at bit 1, IDL at bit 0}. Bits 7..4 always read 0, and all bits read 0 after a core reset.
- R2: GF1 and GF0 take the written bits 3 and 2 on every write and have no effect on any clock enable.
- R3: A write with bit 0 = 1 and bit 1 = 0 sets IDL on the next clock. The CPU clock enable then drops, while the peripheral clock enable and the oscillator enable stay high.
- R4: A write with bit 1 = 1 sets PD on the next clock, and the oscillator enable and both clock enables go low. IDL is stored as 0 in that case, so idle is not entered when power-down ends.
- R5: While IDL is set and PD is clear, any set bit of irq_pend clears IDL on the next clock and restores the CPU clock. If a write that sets IDL falls in the same cycle as a pending interrupt, the interrupt wins and IDL stays 0.
- R6: While PD is set, only a low level on an external line whose ext_en bit is 1 clears PD. That line is seen through a two-flop synchronizer. irq_pend, disabled external lines and register writes leave PD set.
- R7: After PD clears, osc_en is high. per_clk_en and cpu_clk_en stay low until osc_ready has been sampled high on OSC_WAIT consecutive clocks. A low sample restarts the count. The same wait follows every reset pin release.
- R8: After a wake from power-down, cpu_clk_en stays low until no enabled external line is low at the synchronizer output.
- R9: A high level on rst_pin clears PD and IDL asynchronously, so osc_en rises within the same cycle. Mode logic resumes on the third clock edge after the pin is sampled low.
- R10: core_rst goes high only when rst_pin has been high for RST_CYC consecutive clock edges. A pulse one edge shorter changes nothing, and the GF bits are kept. A core reset clears GF1 and GF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Raw reset pin, active high, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| irq_pend | input | N_IRQ | Enabled, pending interrupt requests |
| ext_en | input | N_EXT | Enable mask for the external wake lines |
| ext_int_n | input | N_EXT | External interrupt lines, active low |
| osc_ready | input | 1 | Oscillator stable indication |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| core_rst | output | 1 | Filtered, synchronized core reset |

## Verification
Two events can land on the same clock edge: a software write that sets idle, and a pending interrupt. The bench raises irq_pend in the very cycle that carries the write. It then expects IDL to read 0 and the CPU clock to stay on. A second collision is the reset pin rising while power-down is active. The bench probes osc_en one nanosecond after the pin rises, before the next edge, and expects it high. A behavioural model compares every output on every clock.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
    localparam int CFG_W    = 8;
    localparam int BIT_IDLE = 0;
    localparam int BIT_DOWN = 1;
    localparam int BIT_GF0  = 2;
    localparam int BIT_GF1  = 3;
endpackage

// File: rtl/pmc_sync.sv
`timescale 1ns/1ps
module pmc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = din;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk) begin
        sy_q <= sy_d;
    end

    assign dout = sy_q.s2;
endmodule

// File: rtl/pmc_rst_filter.sv
`timescale 1ns/1ps
module pmc_rst_filter #(
    parameter int RST_CYC = 24
) (
    input  logic clk,
    input  logic rst_pin,
    output logic core_rst,
    output logic clr_n
);
    localparam int CW = $clog2(RST_CYC) + 1;
    localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          hit;
    } flt_t;

    flt_t       flt_d, flt_q;
    logic       pin_s;
    logic [1:0] rel_q;

    pmc_sync #(.W(1)) u_pin_sync (
        .clk  (clk),
        .din  (rst_pin),
        .dout (pin_s)
    );

    always_comb begin
        flt_d = flt_q;
        if (!pin_s) begin
            flt_d.cnt = '0;
        end else if (flt_q.cnt != LAST) begin
            flt_d.cnt = flt_q.cnt + CW'(1);
        end
        flt_d.hit = pin_s && (flt_q.cnt == LAST);
    end

    always_ff @(posedge clk) begin
        flt_q <= flt_d;
    end

    // clear asserts with the pin, releases on the second clock after it
    always_ff @(posedge clk or posedge rst_pin) begin
        if (rst_pin) begin
            rel_q <= 2'b00;
        end else begin
            rel_q <= {rel_q[0], 1'b1};
        end
    end

    assign core_rst = flt_q.hit;
    assign clr_n    = rel_q[1];
endmodule

// File: rtl/pmc_mode_fsm.sv
`timescale 1ns/1ps
module pmc_mode_fsm #(
    parameter int OSC_WAIT = 16
) (
    input  logic clk,
    input  logic clr_n,
    input  logic wr_en,
    input  logic wr_idle,
    input  logic wr_down,
    input  logic irq_any,
    input  logic ext_act,
    input  logic osc_ready,
    output logic down,
    output logic idle,
    output logic osc_en,
    output logic cpu_clk_en,
    output logic per_clk_en
);
    localparam int WW = $clog2(OSC_WAIT) + 1;
    localparam logic [WW-1:0] LAST = WW'(OSC_WAIT - 1);

    typedef struct packed {
        logic          down;
        logic          idle;
        logic          hold;
        logic          up;
        logic [WW-1:0] cnt;
    } mode_t;

    mode_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.down) begin
            if (ext_act) begin
                st_d.down = 1'b0;
                st_d.idle = 1'b0;
                st_d.hold = 1'b1;
            end
        end else begin
            if (!st_q.up) begin
                if (!osc_ready) begin
                    st_d.cnt = '0;
                end else if (st_q.cnt == LAST) begin
                    st_d.up  = 1'b1;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + WW'(1);
                end
            end
            if (st_q.hold && !ext_act) begin
                st_d.hold = 1'b0;
            end
            if (wr_en) begin
                st_d.down = wr_down;
                st_d.idle = wr_idle && !wr_down;
                if (wr_down) begin
                    st_d.up  = 1'b0;
                    st_d.cnt = '0;
                end
            end
            if (irq_any) begin
                st_d.idle = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign down       = st_q.down;
    assign idle       = st_q.idle;
    assign osc_en     = !st_q.down;
    assign per_clk_en = st_q.up;
    assign cpu_clk_en = st_q.up && !st_q.idle && !st_q.hold;
endmodule

// File: rtl/pwr_mode_ctl.sv
`timescale 1ns/1ps
module pwr_mode_ctl
    import pmc_pkg::*;
#(
    parameter int N_IRQ    = 4,
    parameter int N_EXT    = 2,
    parameter int RST_CYC  = 24,
    parameter int OSC_WAIT = 16
) (
    input  logic             clk,
    input  logic             rst_pin,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_EXT-1:0] ext_en,
    input  logic [N_EXT-1:0] ext_int_n,
    input  logic             osc_ready,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en,
    output logic             core_rst
);
    logic             clr_n;
    logic [N_EXT-1:0] ext_s;
    logic             ext_act;
    logic             down;
    logic             idle;
    logic [1:0]       gf_d, gf_q;
    logic             unused_hi;

    assign unused_hi = ^wr_data[CFG_W-1:BIT_GF1+1];

    pmc_rst_filter #(.RST_CYC(RST_CYC)) u_filter (
        .clk      (clk),
        .rst_pin  (rst_pin),
        .core_rst (core_rst),
        .clr_n    (clr_n)
    );

    pmc_sync #(.W(N_EXT)) u_ext_sync (
        .clk  (clk),
        .din  (ext_int_n),
        .dout (ext_s)
    );

    assign ext_act = |(ext_en & ~ext_s);

    pmc_mode_fsm #(.OSC_WAIT(OSC_WAIT)) u_fsm (
        .clk        (clk),
        .clr_n      (clr_n),
        .wr_en      (wr_en),
        .wr_idle    (wr_data[BIT_IDLE]),
        .wr_down    (wr_data[BIT_DOWN]),
        .irq_any    (|irq_pend),
        .ext_act    (ext_act),
        .osc_ready  (osc_ready),
        .down       (down),
        .idle       (idle),
        .osc_en     (osc_en),
        .cpu_clk_en (cpu_clk_en),
        .per_clk_en (per_clk_en)
    );

    always_comb begin
        gf_d = gf_q;
        if (core_rst) begin
            gf_d = 2'b00;
        end else if (wr_en) begin
            gf_d = {wr_data[BIT_GF1], wr_data[BIT_GF0]};
        end
    end

    always_ff @(posedge clk) begin
        gf_q <= gf_d;
    end

    always_comb begin
        rd_data           = '0;
        rd_data[BIT_IDLE] = idle;
        rd_data[BIT_DOWN] = down;
        rd_data[BIT_GF0]  = gf_q[0];
        rd_data[BIT_GF1]  = gf_q[1];
    end
endmodule

// File: rtl/pwr_mode_ctl_chk.sv
`timescale 1ns/1ps
module pwr_mode_ctl_chk (
    input logic       clk,
    input logic       rst_pin,
    input logic       wr_en,
    input logic       wr_idle,
    input logic       wr_down,
    input logic       irq_any,
    input logic       ext_act,
    input logic [1:0] mode_bits,
    input logic       cpu_clk_en,
    input logic       per_clk_en
);
    // R4: power-down is only ever entered by a software write
    a_r4_down_by_write: assert property (@(posedge clk) disable iff (rst_pin)
        $rose(mode_bits[1]) |-> $past(wr_en && wr_down));

    // R3: idle is only entered by a write with no interrupt pending
    a_r3_idle_by_write: assert property (@(posedge clk) disable iff (rst_pin)
        $rose(mode_bits[0]) |-> $past(wr_en && wr_idle && !wr_down && !irq_any));

    // R5: pending interrupt ends idle on the next clock
    a_r5_irq_ends_idle: assert property (@(posedge clk) disable iff (rst_pin)
        (mode_bits[0] && !mode_bits[1] && irq_any) |=> !mode_bits[0]);

    // R6: power-down ends only on an enabled external line
    a_r6_down_exit_ext: assert property (@(posedge clk) disable iff (rst_pin)
        $fell(mode_bits[1]) |-> $past(ext_act));

    // R7: the CPU never runs without the peripheral clock
    a_r7_cpu_needs_per: assert property (@(posedge clk) disable iff (rst_pin)
        cpu_clk_en |-> per_clk_en);
endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk u_chk (
    .clk        (clk),
    .rst_pin    (rst_pin),
    .wr_en      (wr_en),
    .wr_idle    (wr_data[0]),
    .wr_down    (wr_data[1]),
    .irq_any    (|irq_pend),
    .ext_act    (ext_act),
    .mode_bits  (rd_data[1:0]),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en)
);

// File: tb/tb_pwr_mode_ctl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctl;
    localparam int N_IRQ    = 4;
    localparam int N_EXT    = 2;
    localparam int RST_CYC  = 24;
    localparam int OSC_WAIT = 16;

    logic       clk = 1'b0;
    logic       rst_pin;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [3:0] irq_pend;
    logic [1:0] ext_en;
    logic [1:0] ext_int_n;
    logic       osc_ready;
    logic       cpu_clk_en, per_clk_en, osc_en, core_rst;

    int n_chk  = 0;
    int n_fail = 0;
    bit cmp_on = 0;
    bit seen   = 0;

    always #2.5 clk = ~clk;

    pwr_mode_ctl #(.N_IRQ(N_IRQ), .N_EXT(N_EXT), .RST_CYC(RST_CYC),
                   .OSC_WAIT(OSC_WAIT)) dut (
        .clk(clk), .rst_pin(rst_pin), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq_pend(irq_pend), .ext_en(ext_en),
        .ext_int_n(ext_int_n), .osc_ready(osc_ready), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .osc_en(osc_en), .core_rst(core_rst)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic pin_h[$];
    logic [1:0] ext_h[$];
    bit m_down = 0, m_idle = 0, m_hold = 0, m_up = 0, m_crst = 0;
    int m_run = 0;
    logic [1:0] m_gf = 2'b00;

    always @(posedge rst_pin) begin
        m_down = 0; m_idle = 0; m_hold = 0; m_up = 0; m_run = 0;
    end

    always @(posedge clk) begin
        logic [1:0] ext_old;
        bit act, run_ok, all_hi;
        if (m_crst) m_gf = 2'b00;
        else if (wr_en) m_gf = wr_data[3:2];
        pin_h.push_back(rst_pin);
        if (pin_h.size() > RST_CYC + 2) void'(pin_h.pop_front());
        all_hi = (pin_h.size() == RST_CYC + 2);
        for (int i = 0; i < RST_CYC; i++)
            if (all_hi && pin_h[i] != 1'b1) all_hi = 0;
        m_crst = all_hi;
        ext_h.push_back(ext_int_n);
        if (ext_h.size() > 3) void'(ext_h.pop_front());
        ext_old = (ext_h.size() == 3) ? ext_h[0] : 2'b11;
        act = |(ext_en & ~ext_old);
        run_ok = pin_h.size() >= 3 && pin_h[pin_h.size()-1] == 0 &&
                 pin_h[pin_h.size()-2] == 0 && pin_h[pin_h.size()-3] == 0;
        if (!run_ok) begin
            m_down = 0; m_idle = 0; m_hold = 0; m_up = 0; m_run = 0;
        end else if (m_down) begin
            if (act) begin m_down = 0; m_idle = 0; m_hold = 1; end
        end else begin
            if (!m_up) begin
                if (osc_ready) begin
                    m_run++;
                    if (m_run == OSC_WAIT) begin m_up = 1; m_run = 0; end
                end else m_run = 0;
            end
            if (m_hold && !act) m_hold = 0;
            if (wr_en) begin
                m_down = wr_data[1];
                m_idle = wr_data[0] && !wr_data[1];
                if (wr_data[1]) begin m_up = 0; m_run = 0; end
            end
            if (irq_pend != 0) m_idle = 0;
        end
    end

    always @(negedge clk) begin
        if (core_rst) seen = 1;
        if (cmp_on) begin
            chk(osc_en, !m_down, "R4 model osc_en");
            chk(per_clk_en, m_up, "R7 model per_clk_en");
            chk(cpu_clk_en, m_up && !m_idle && !m_hold, "R3 model cpu_clk_en");
            chk(core_rst, m_crst, "R10 model core_rst");
            chk(rd_data, {4'b0000, m_gf, m_down, m_idle}, "R1 model rd_data");
        end
    end

    task automatic tick;
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1; wr_data = d; tick; wr_en = 0;
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_pin = 1; wr_en = 0; wr_data = 0; irq_pend = 0;
        ext_en = 2'b11; ext_int_n = 2'b11; osc_ready = 1;
        repeat (30) tick;
        cmp_on = 1;
        repeat (10) tick;
        @(negedge clk); chk(core_rst, 1, "R10 long pin pulse");
        tick; rst_pin = 0;
        repeat (3) tick;
        @(negedge clk);
        chk(rd_data, 8'h00, "R1 reset value");
        chk(core_rst, 0, "R10 release");
        chk(per_clk_en, 0, "R7 settle after reset");
        repeat (OSC_WAIT + 2) tick;
        @(negedge clk); chk(cpu_clk_en, 1, "R7 clocks after settle");

        wr(8'hFC);
        @(negedge clk);
        chk(rd_data, 8'h0C, "R1 reserved bits read 0");
        chk(cpu_clk_en, 1, "R2 flags leave clocks on");

        wr(8'h01);
        @(negedge clk);
        chk(cpu_clk_en, 0, "R3 idle stops cpu");
        chk(per_clk_en, 1, "R3 idle keeps periph");
        chk(osc_en, 1, "R3 idle keeps osc");
        repeat (3) tick;
        irq_pend = 4'b0100; tick; irq_pend = 0;
        @(negedge clk);
        chk(rd_data[0], 0, "R5 irq clears idle");
        chk(cpu_clk_en, 1, "R5 cpu restored");

        wr_en = 1; wr_data = 8'h01; irq_pend = 4'b0001; tick;
        wr_en = 0; irq_pend = 0;
        @(negedge clk);
        chk(rd_data[0], 0, "R5 irq beats idle write");
        chk(cpu_clk_en, 1, "R5 cpu stays on");

        wr(8'h0F);
        @(negedge clk);
        chk(rd_data, 8'h0E, "R4 pd wins, idle stored 0");
        chk(osc_en, 0, "R4 osc stopped");
        chk(per_clk_en, 0, "R4 periph stopped");

        irq_pend = 4'hF; ext_en = 2'b01; ext_int_n = 2'b01;
        repeat (5) tick;
        @(negedge clk);
        chk(rd_data[1], 1, "R6 irq and disabled line ignored");
        chk(osc_en, 0, "R6 osc still off");
        irq_pend = 0; ext_en = 2'b11;
        repeat (4) tick;
        @(negedge clk);
        chk(rd_data[1:0], 2'b00, "R6 enabled low line wakes, R4 no idle");
        chk(osc_en, 1, "R7 osc restarted");
        chk(per_clk_en, 0, "R7 clocks withheld");
        osc_ready = 0; repeat (3) tick;
        osc_ready = 1; repeat (OSC_WAIT - 2) tick;
        @(negedge clk); chk(per_clk_en, 0, "R7 count restarted");
        repeat (4) tick;
        @(negedge clk);
        chk(per_clk_en, 1, "R7 periph after settle");
        chk(cpu_clk_en, 0, "R8 cpu held while line low");
        ext_int_n = 2'b11; tick;
        @(negedge clk); chk(cpu_clk_en, 0, "R8 synchronizer delay");
        repeat (3) tick;
        @(negedge clk); chk(cpu_clk_en, 1, "R8 cpu after release");

        wr(8'h0D);
        seen = 0;
        @(posedge clk); #1 rst_pin = 1;
        #1 chk(rd_data[0], 0, "R9 async idle clear");
        repeat (4) tick; rst_pin = 0;
        repeat (4) tick;
        @(negedge clk);
        chk(seen, 0, "R10 short pulse no reset");
        chk(rd_data, 8'h0C, "R10 flags kept");
        repeat (OSC_WAIT + 2) tick;

        wr(8'h0E);
        @(negedge clk); chk(osc_en, 0, "R4 pd before pin");
        @(posedge clk); #1 rst_pin = 1;
        #1 chk(osc_en, 1, "R9 async pd clear");
        repeat (RST_CYC - 1) tick; rst_pin = 0;
        repeat (4) tick;
        @(negedge clk);
        chk(seen, 0, "R10 one edge short");
        chk(rd_data, 8'h0C, "R10 flags kept at boundary");

        tick; rst_pin = 1;
        repeat (RST_CYC) tick; rst_pin = 0;
        repeat (4) tick;
        @(negedge clk);
        chk(seen, 1, "R10 exact length resets");
        chk(rd_data, 8'h00, "R10 flags cleared");
        repeat (OSC_WAIT + 4) tick;
        @(negedge clk); chk(cpu_clk_en, 1, "R7 running at end");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule